// File: doc/BRIEF.md
# Converter Pair Request Scheduler

This block decides the order in which three converter pairs (A, B, C) use a single shared conversion engine. Each pair has an active-low hold request line. A high-to-low transition on a line is captured on the falling clock edge. On the following rising edge the request either launches a conversion at once or joins an ordered queue. Requests that fall in the same clock cycle are ordered A, then B, then C. A request from an earlier cycle always keeps its place ahead of later ones, so a running conversion is never interrupted.

The engine is modelled inside the block as a fixed-latency timer. When a conversion finishes, the block hands off the pair identity over two consecutive cycles, one beat for each of the pair's two result sub-channels. A busy flag covers the whole span of started and queued work. Reset drops every pending request.

Top module: `conv_req_sched`

## Requirements
- R1: A high-to-low transition on `hold_n[p]` that is present at a falling clock edge starts a conversion in the clock cycle that begins at the next rising edge, if the engine is idle. The start shows as `conv_start` high for one cycle, with `conv_pair` = p (A=0 on bit 0, B=1 on bit 1, C=2 on bit 2).
- R2: Requests captured at the same falling edge are converted in ascending pair order: A before B before C.
- R3: A request captured at an earlier falling edge is converted before any captured later, whatever their pair order. A running conversion is never pre-empted.
- R4: The done beat comes 14 cycles after the start cycle: `hand_valid`=1, `hand_sub`=0, `hand_pair` = converted pair. In the next cycle `hand_valid`=1, `hand_sub`=1, with the same pair.
- R5: When work is queued, the next conversion starts in the cycle right after the previous done beat, so starts are 15 cycles apart.
- R6: `busy` is high from the first start cycle through the done beat of the last queued conversion, and low otherwise. For a group of n back-to-back conversions it is high for exactly 15·n cycles.
- R7: A hold line that stays low generates only one request. Only a new high-to-low transition counts.
- R8: A request for a pair that is already queued or converting is ignored. After that pair's done beat, a new request is accepted.
- R9: Reset empties the queue and stops the engine: `busy`, `conv_start` and `hand_valid` are low during reset, and no queued pair starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; requests sampled on falling edge, scheduling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n | input | 3 | Active-low hold requests, bit 0 = A, bit 1 = B, bit 2 = C |
| conv_start | output | 1 | One-cycle start pulse to the conversion engine |
| conv_pair | output | 2 | Pair being converted |
| busy | output | 1 | Conversion running or pending |
| hand_valid | output | 1 | Result handoff beat valid |
| hand_pair | output | 2 | Pair identity of the finished conversion |
| hand_sub | output | 1 | Sub-channel of the handoff beat (0 then 1) |

## Verification
The following hold on every cycle and are checked continuously:
- `busy` rises only together with a start and falls only right after a done beat.
- A start that follows busy activity is always preceded by a done beat, so no conversion is pre-empted.
- Every first handoff beat is followed by a second beat carrying the same pair.

Some behaviour can only be shown by the bench scenarios. These are the exact start cycles and the conversion order across every split of requests between two consecutive cycles. They also include suppression of held or repeated requests, and the empty state after a reset in mid-operation.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  localparam int NPAIRS_DEF = 3;
  localparam int CONV_CYCLES_DEF = 14;
endpackage

// File: rtl/hold_edge_capture.sv
module hold_edge_capture #(
  parameter int NPAIRS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPAIRS-1:0] hold_n,
  output logic [NPAIRS-1:0] req_vec
);
  logic [NPAIRS-1:0] prev_q, prev_d;
  logic [NPAIRS-1:0] req_q, req_d;

  always_comb begin
    prev_d = hold_n;
    req_d  = prev_q & ~hold_n;
  end

  // falling-edge capture stage
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      req_q  <= '0;
    end else begin
      prev_q <= prev_d;
      req_q  <= req_d;
    end
  end

  assign req_vec = req_q;
endmodule

// File: rtl/pair_order_queue.sv
module pair_order_queue #(
  parameter int NPAIRS = 3,
  localparam int PW = (NPAIRS > 1) ? $clog2(NPAIRS) : 1,
  localparam int CW = $clog2(NPAIRS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic [NPAIRS-1:0] push_vec,
  output logic [PW-1:0]     head,
  output logic [CW-1:0]     count
);
  logic [PW-1:0] ent_q [NPAIRS];
  logic [PW-1:0] ent_d [NPAIRS];
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    for (int i = 0; i < NPAIRS; i++) ent_d[i] = ent_q[i];
    cnt_d = cnt_q;
    if (pop && (cnt_q != '0)) begin
      for (int i = 0; i < NPAIRS - 1; i++) ent_d[i] = ent_q[i+1];
      ent_d[NPAIRS-1] = '0;
      cnt_d = cnt_q - CW'(1);
    end
    // same-cycle arrivals appended in ascending pair order
    for (int p = 0; p < NPAIRS; p++) begin
      if (push_vec[p] && (int'(cnt_d) < NPAIRS)) begin
        ent_d[cnt_d] = PW'(p);
        cnt_d = cnt_d + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAIRS; i++) ent_q[i] <= '0;
      cnt_q <= '0;
    end else begin
      for (int i = 0; i < NPAIRS; i++) ent_q[i] <= ent_d[i];
      cnt_q <= cnt_d;
    end
  end

  assign head  = ent_q[0];
  assign count = cnt_q;
endmodule

// File: rtl/conv_engine_model.sv
module conv_engine_model #(
  parameter int CONV_CYCLES = 14,
  parameter int PW = 2,
  localparam int TW = $clog2(CONV_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [PW-1:0] launch_pair,
  output logic          running,
  output logic [PW-1:0] cur_pair,
  output logic          start,
  output logic          done,
  output logic          hand_valid,
  output logic [PW-1:0] hand_pair,
  output logic          hand_sub
);
  logic          run_q, run_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [PW-1:0] pair_q, pair_d;
  logic          beat2_q, beat2_d;
  logic [PW-1:0] beat2_pair_q, beat2_pair_d;

  assign done  = run_q && (tmr_q == '0);
  assign start = run_q && (tmr_q == TW'(CONV_CYCLES));

  always_comb begin
    run_d        = run_q;
    tmr_d        = tmr_q;
    pair_d       = pair_q;
    beat2_d      = done;
    beat2_pair_d = pair_q;
    if (launch) begin
      run_d  = 1'b1;
      tmr_d  = TW'(CONV_CYCLES);
      pair_d = launch_pair;
    end else if (done) begin
      run_d = 1'b0;
    end else if (run_q) begin
      tmr_d = tmr_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q        <= 1'b0;
      tmr_q        <= '0;
      pair_q       <= '0;
      beat2_q      <= 1'b0;
      beat2_pair_q <= '0;
    end else begin
      run_q        <= run_d;
      tmr_q        <= tmr_d;
      pair_q       <= pair_d;
      beat2_q      <= beat2_d;
      beat2_pair_q <= beat2_pair_d;
    end
  end

  assign running    = run_q;
  assign cur_pair   = pair_q;
  assign hand_valid = done || beat2_q;
  assign hand_pair  = done ? pair_q : beat2_pair_q;
  assign hand_sub   = !done;
endmodule

// File: rtl/conv_req_sched.sv
module conv_req_sched
  import conv_sched_pkg::*;
#(
  parameter int NPAIRS = NPAIRS_DEF,
  parameter int CONV_CYCLES = CONV_CYCLES_DEF,
  localparam int PW = (NPAIRS > 1) ? $clog2(NPAIRS) : 1,
  localparam int CW = $clog2(NPAIRS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPAIRS-1:0] hold_n,
  output logic              conv_start,
  output logic [PW-1:0]     conv_pair,
  output logic              busy,
  output logic              hand_valid,
  output logic [PW-1:0]     hand_pair,
  output logic              hand_sub
);
  logic [NPAIRS-1:0] req_vec;
  logic [NPAIRS-1:0] inflight_q, inflight_d;
  logic [NPAIRS-1:0] done_mask, inflight_eff, acc_vec, push_vec;
  logic [PW-1:0]     q_head, launch_pair, lowest;
  logic [CW-1:0]     q_count;
  logic              running, done, free, launch, pop;
  logic [PW-1:0]     cur_pair;

  hold_edge_capture #(.NPAIRS(NPAIRS)) u_cap (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .req_vec(req_vec)
  );

  pair_order_queue #(.NPAIRS(NPAIRS)) u_queue (
    .clk(clk), .rst_n(rst_n), .pop(pop), .push_vec(push_vec),
    .head(q_head), .count(q_count)
  );

  conv_engine_model #(.CONV_CYCLES(CONV_CYCLES), .PW(PW)) u_eng (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_pair(launch_pair),
    .running(running), .cur_pair(cur_pair), .start(conv_start), .done(done),
    .hand_valid(hand_valid), .hand_pair(hand_pair), .hand_sub(hand_sub)
  );

  always_comb begin
    done_mask    = done ? (NPAIRS'(1) << cur_pair) : '0;
    inflight_eff = inflight_q & ~done_mask;
    acc_vec      = req_vec & ~inflight_eff;
    lowest       = '0;
    for (int p = NPAIRS - 1; p >= 0; p--) begin
      if (acc_vec[p]) lowest = PW'(p);
    end
    free        = !running || done;
    launch      = 1'b0;
    pop         = 1'b0;
    launch_pair = '0;
    push_vec    = acc_vec;
    if (free) begin
      if (q_count != '0) begin
        launch      = 1'b1;
        pop         = 1'b1;
        launch_pair = q_head;
      end else if (acc_vec != '0) begin
        launch      = 1'b1;
        launch_pair = lowest;
        push_vec    = acc_vec & ~(NPAIRS'(1) << lowest);
      end
    end
    inflight_d = inflight_eff | acc_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight_q <= '0;
    else        inflight_q <= inflight_d;
  end

  assign conv_pair = cur_pair;
  assign busy      = running || (q_count != '0);
endmodule

// File: rtl/conv_req_sched_chk.sv
module conv_req_sched_chk #(
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_start,
  input logic [PW-1:0] conv_pair,
  input logic          busy,
  input logic          hand_valid,
  input logic [PW-1:0] hand_pair,
  input logic          hand_sub
);
  // R6
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> conv_start);
  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(hand_valid && !hand_sub));
  // R4
  second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hand_valid && !hand_sub) |=> (hand_valid && hand_sub && hand_pair == $past(hand_pair)));
  // R3
  no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && $past(busy)) |-> $past(hand_valid && !hand_sub));
endmodule

bind conv_req_sched conv_req_sched_chk #(.PW(PW)) u_chk (.*);

// File: tb/conv_req_sched_bench.sv
module conv_req_sched_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hold_n = 3'b111;
  logic       conv_start, busy, hand_valid, hand_sub;
  logic [1:0] conv_pair, hand_pair;

  int checks = 0, errors = 0, cyc = 0;
  int n_st = 0, n_hd = 0, busy_cnt = 0;
  int st_pair [512], st_cyc [512];
  int hd_pair [1024], hd_sub [1024], hd_cyc [1024];

  always #2 clk = ~clk;

  conv_req_sched u_conv_req_sched (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .conv_start(conv_start),
    .conv_pair(conv_pair), .busy(busy), .hand_valid(hand_valid),
    .hand_pair(hand_pair), .hand_sub(hand_sub)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (conv_start) begin
        if (n_st < 512) begin st_pair[n_st] = int'(conv_pair); st_cyc[n_st] = cyc; end
        n_st++;
      end
      if (hand_valid) begin
        if (n_hd < 1024) begin
          hd_pair[n_hd] = int'(hand_pair); hd_sub[n_hd] = int'(hand_sub); hd_cyc[n_hd] = cyc;
        end
        n_hd++;
      end
    end
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    hold_n = 3'b111;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
  endtask

  // first: lines falling in cycle c0; second: lines falling in c0+1
  task automatic run_case(input logic [2:0] first, input logic [2:0] second, input int hold_cyc);
    int exp_p [6];
    int len, b_st, b_hd, b_busy, t0;
    len = 0;
    for (int p = 0; p < 3; p++) if (first[p]) begin exp_p[len] = p; len++; end
    for (int p = 0; p < 3; p++) if (second[p] && !first[p]) begin exp_p[len] = p; len++; end
    do_reset();
    b_st = n_st; b_hd = n_hd; b_busy = busy_cnt;
    t0 = (first != 3'b000) ? cyc + 1 : cyc + 2;
    hold_n = ~first;
    @(posedge clk); #1;
    hold_n = ~(first | second);
    repeat (hold_cyc) @(posedge clk);
    #1 hold_n = 3'b111;
    repeat (len * 15 + 20) @(posedge clk);
    #1;
    // R2 R3 R7: number of starts equals distinct requested pairs
    chk(n_st - b_st == len, "R2/R3 start count", n_st - b_st, len);
    for (int i = 0; i < len; i++) begin
      // R1 R2 R3 order and R5 spacing
      chk(st_pair[b_st+i] == exp_p[i], "R2/R3 order", st_pair[b_st+i], exp_p[i]);
      chk(st_cyc[b_st+i] == t0 + 15*i, "R1/R5 start cycle", st_cyc[b_st+i], t0 + 15*i);
      // R4 handoff beats
      chk(hd_pair[b_hd+2*i] == exp_p[i] && hd_sub[b_hd+2*i] == 0,
          "R4 beat0 pair", hd_pair[b_hd+2*i], exp_p[i]);
      chk(hd_cyc[b_hd+2*i] == t0 + 15*i + 14, "R4 done cycle", hd_cyc[b_hd+2*i], t0 + 15*i + 14);
      chk(hd_pair[b_hd+2*i+1] == exp_p[i] && hd_sub[b_hd+2*i+1] == 1,
          "R4 beat1 pair", hd_pair[b_hd+2*i+1], exp_p[i]);
    end
    // R6 busy duration
    chk(busy_cnt - b_busy == 15 * len, "R6 busy cycles", busy_cnt - b_busy, 15 * len);
    chk(busy == 1'b0, "R6 busy idle", int'(busy), 0);
  endtask

  initial begin
    int b_st;
    // R9 reset state
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk(!busy && !conv_start && !hand_valid, "R9 reset outputs", int'({busy, conv_start, hand_valid}), 0);

    for (int f = 0; f < 8; f++)
      for (int s = 0; s < 8; s++)
        if (((f & s) == 0) && ((f | s) != 0))
          run_case(3'(f), 3'(s), 2);

    // R7 held low for many cycles gives one conversion each
    run_case(3'b101, 3'b000, 60);

    // R8 re-pulse of pending A and converting B ignored
    do_reset();
    b_st = n_st;
    hold_n = 3'b101;               // B
    @(posedge clk); #1 hold_n = 3'b100;   // A
    @(posedge clk); #1 hold_n = 3'b111;
    @(posedge clk); #1 hold_n = 3'b100;   // A and B again while busy
    @(posedge clk); #1 hold_n = 3'b111;
    repeat (50) @(posedge clk); #1;
    chk(n_st - b_st == 2, "R8 duplicate ignored", n_st - b_st, 2);
    // R8 accepted again after done
    hold_n = 3'b101;
    @(posedge clk); #1 hold_n = 3'b111;
    repeat (20) @(posedge clk); #1;
    chk(n_st - b_st == 3 && st_pair[b_st+2] == 1, "R8 accepted after done", n_st - b_st, 3);

    // R9 reset mid-operation clears queue
    do_reset();
    b_st = n_st;
    hold_n = 3'b000;
    @(posedge clk); #1 hold_n = 3'b111;
    repeat (20) @(posedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk(!busy && !hand_valid && !conv_start, "R9 reset clears", int'({busy, hand_valid, conv_start}), 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (60) @(posedge clk); #1;
    chk(n_st - b_st == 2, "R9 no start after reset", n_st - b_st, 2);
    chk(busy == 1'b0, "R9 idle after reset", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule